// File: doc/BRIEF.md
# Exception Return Context Restore Sequencer

This block performs the register-side work of a return from an interrupt or trap. A single-cycle `start` pulse presents four words: the previous-context link word, the status word, the interrupt control word and the free-context pointer. The block first runs three ordered legality checks on these words. If any check fails, one trap code is reported and nothing else changes.

When all checks pass, the block loads the interrupt enable and current priority from the link word. It then builds the address of the saved context area from the link word's segment and offset fields. Sixteen words are read from that area through a word-wide request/ready port. Each returned word is forwarded to the register file with its slot index. The block then writes the old free-context pointer into the first word of the area, which puts the area back on the free list. Finally it updates the free-context pointer and the link word and pulses `done`.

The call depth field in the status word is variable-width. A run of leading ones, followed by one zero separator bit, sets how many low bits form the counter. The pattern with all seven bits set counts as zero.

Top module: `rfe_restore_seq`

## Requirements
- R1: When `start` is accepted and `link_in[19:0]` is zero, `trap_valid` pulses one cycle later with `trap_code` = 1. No memory request is issued and `done` stays low.
- R2: When `link_in[19:0]` is non-zero and the upper-context flag `link_in[20]` is 0, the trap reported is `trap_code` = 2.
- R3: When the first two checks pass, `status_in[7]` (depth check enable) is 1 and the decoded call depth is non-zero, the trap reported is `trap_code` = 3. With `status_in[7]` = 0 no depth trap occurs.
- R4: The depth field is `status_in[6:0]`. Let n be the count of leading ones from bit 6. The counter is the low (6-n) bits. When n ≥ 6 (this includes 1111111 and 1111110), the depth is zero.
- R5: The checks are ranked R1, then R2, then R3. Only the first failing check is reported.
- R6: After a successful restore, `icr_out` equals `icr_in` with bit 8 replaced by `link_in[21]` and bits 7:0 replaced by `link_in[31:24]`. All other bits are unchanged.
- R7: The context address is EA = {`link_in[19:16]`, 6'b0, `link_in[15:0]`, 6'b0}. Read k (k = 0..15) uses address EA+4k.
- R8: Reads occur in slot order 0..15. Slot 0 is the new link word, 1 the status word, 2-3 A10-A11, 4-7 D8-D11, 8-11 A12-A15 and 12-15 D12-D15. Each accepted read drives `ctx_wr_en` with `ctx_wr_idx` = k and `ctx_wr_data` = `mem_rdata`. `status_out` takes slot 1.
- R9: After the 16th read, one write is issued with `mem_we` = 1 to address EA, carrying `fcx_in`.
- R10: On completion, `fcx_out` = {`fcx_in[31:20]`, `link_in[19:0]`} and `link_out` = the slot 0 word.
- R11: A request stays asserted with a stable address and direction until `mem_ready` is high. Exactly one access is accepted per ready cycle.
- R12: `done` is a one-cycle pulse in the cycle after the write is accepted. `busy` is low at that time.
- R13: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a return sequence (accepted when idle) |
| link_in | input | 32 | Current previous-context link word |
| status_in | input | 32 | Current status word |
| icr_in | input | 32 | Current interrupt control word |
| fcx_in | input | 32 | Current free-context pointer |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Restore completed pulse |
| trap_valid | output | 1 | Trap reported pulse |
| trap_code | output | 2 | 1 underflow, 2 context type, 3 nesting |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request accepted |
| link_out | output | 32 | Updated link word |
| status_out | output | 32 | Restored status word |
| icr_out | output | 32 | Updated interrupt control word |
| fcx_out | output | 32 | Updated free-context pointer |
| ctx_wr_en | output | 1 | Restored register write strobe |
| ctx_wr_idx | output | 4 | Context slot of the restored word |
| ctx_wr_data | output | 32 | Restored word |

## Verification
The hardest case to reach is the depth decode near its edges. These are field widths of zero and one, where a leading-ones miscount turns a legal depth into a nesting trap or hides a real one. The vector table therefore covers each prefix length with a zero and a non-zero counter, and includes the two seven-bit patterns that must decode as zero. A second hard area is back-pressure during the restore. The memory model withholds `mem_ready` on every third cycle, so requests must be held across stalls. Every slot index, every address and the final write are then compared with values computed from the link word.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int WORD_W    = 32;
  localparam int CTX_WORDS = 16;
  localparam int SLOT_W    = $clog2(CTX_WORDS);
  localparam int DEPTH_W   = 7;

  // link word layout
  localparam int LNK_OFF_LSB = 0;
  localparam int LNK_OFF_W   = 16;
  localparam int LNK_SEG_LSB = 16;
  localparam int LNK_SEG_W   = 4;
  localparam int LNK_PTR_W   = 20;
  localparam int LNK_UPPER   = 20;
  localparam int LNK_PIE     = 21;
  localparam int LNK_PPRI_LSB = 24;
  localparam int PRI_W       = 8;

  // status word layout
  localparam int ST_DEPTH_LSB = 0;
  localparam int ST_DEPTH_EN  = 7;

  // interrupt control layout
  localparam int ICR_PRI_LSB = 0;
  localparam int ICR_IE      = 8;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_UNDER = 2'd1,
    TRAP_TYPE  = 2'd2,
    TRAP_NEST  = 2'd3
  } trap_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rfe_depth_check.sv
module rfe_depth_check
  import rfe_pkg::*;
#(
  parameter int FIELD_W = DEPTH_W
) (
  input  logic [FIELD_W-1:0] field,
  output logic               is_zero
);
  localparam int CNT_W = $clog2(FIELD_W + 1);

  logic [CNT_W-1:0]   lead_ones;
  logic [FIELD_W-1:0] mask;
  logic               run;

  always_comb begin
    lead_ones = '0;
    run       = 1'b1;
    for (int i = FIELD_W - 1; i >= 0; i--) begin
      if (run && field[i]) lead_ones = lead_ones + 1'b1;
      else                 run = 1'b0;
    end
  end

  always_comb begin
    mask    = '0;
    is_zero = 1'b1;
    if (int'(lead_ones) < FIELD_W - 1) begin
      for (int b = 0; b < FIELD_W - 1; b++) begin
        mask[b] = (b < (FIELD_W - 1 - int'(lead_ones)));
      end
      is_zero = ((field & mask) == '0);
    end
  end
endmodule

// File: rtl/rfe_trap_check.sv
module rfe_trap_check
  import rfe_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] link,
  input  logic [W-1:0] status,
  output trap_e        trap
);
  logic depth_zero;

  rfe_depth_check #(.FIELD_W(DEPTH_W)) u_depth (
    .field   (status[ST_DEPTH_LSB +: DEPTH_W]),
    .is_zero (depth_zero)
  );

  always_comb begin
    if (link[LNK_PTR_W-1:0] == '0)                     trap = TRAP_UNDER;
    else if (!link[LNK_UPPER])                         trap = TRAP_TYPE;
    else if (status[ST_DEPTH_EN] && !depth_zero)       trap = TRAP_NEST;
    else                                               trap = TRAP_NONE;
  end
endmodule

// File: rtl/rfe_addr_gen.sv
module rfe_addr_gen
  import rfe_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int SLOTS = CTX_WORDS
) (
  input  logic [W-1:0]             link,
  input  logic [$clog2(SLOTS)-1:0] slot,
  output logic [W-1:0]             base,
  output logic [W-1:0]             slot_addr
);
  localparam int SW    = $clog2(SLOTS);
  localparam int GAP   = W - LNK_SEG_W - LNK_OFF_W - 6;

  assign base = {link[LNK_SEG_LSB +: LNK_SEG_W], {GAP{1'b0}},
                 link[LNK_OFF_LSB +: LNK_OFF_W], 6'b0};
  assign slot_addr = {base[W-1:SW+2], slot, 2'b00};
endmodule

// File: rtl/rfe_seq_ctrl.sv
module rfe_seq_ctrl
  import rfe_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int SLOTS = CTX_WORDS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  trap_e                    trap_in,
  input  logic [W-1:0]             link_in,
  input  logic [W-1:0]             icr_in,
  input  logic [W-1:0]             fcx_in,
  input  logic [W-1:0]             base,
  input  logic [W-1:0]             slot_addr,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic [W-1:0]             link_q_o,
  output logic                     busy,
  output logic                     done,
  output logic                     trap_valid,
  output logic [1:0]               trap_code,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [W-1:0]             mem_addr,
  output logic [W-1:0]             mem_wdata,
  input  logic [W-1:0]             mem_rdata,
  input  logic                     mem_ready,
  output logic [W-1:0]             link_out,
  output logic [W-1:0]             status_out,
  output logic [W-1:0]             icr_out,
  output logic [W-1:0]             fcx_out,
  output logic                     ctx_wr_en,
  output logic [$clog2(SLOTS)-1:0] ctx_wr_idx,
  output logic [W-1:0]             ctx_wr_data
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  seq_state_e  state_q, state_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [W-1:0]  link_q, link_d, fcx_q, fcx_d, new_link_q, new_link_d;
  logic [W-1:0]  status_q, status_d, icr_q, icr_d, fcx_o_q, fcx_o_d, link_o_q, link_o_d;
  logic          done_q, done_d, tv_q, tv_d;
  logic [1:0]    tc_q, tc_d;
  logic          accept, take;

  assign take   = start && (state_q == ST_IDLE);
  assign accept = mem_req && mem_ready;

  always_comb begin
    state_d    = state_q;
    slot_d     = slot_q;
    link_d     = link_q;
    fcx_d      = fcx_q;
    new_link_d = new_link_q;
    status_d   = status_q;
    icr_d      = icr_q;
    fcx_o_d    = fcx_o_q;
    link_o_d   = link_o_q;
    done_d     = 1'b0;
    tv_d       = 1'b0;
    tc_d       = 2'd0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          if (trap_in != TRAP_NONE) begin
            tv_d = 1'b1;
            tc_d = trap_in;
          end else begin
            state_d = ST_READ;
            slot_d  = '0;
            link_d  = link_in;
            fcx_d   = fcx_in;
            icr_d   = icr_in;
            icr_d[ICR_IE] = link_in[LNK_PIE];
            icr_d[ICR_PRI_LSB +: PRI_W] = link_in[LNK_PPRI_LSB +: PRI_W];
          end
        end
      end
      ST_READ: begin
        if (accept) begin
          if (slot_q == '0)        new_link_d = mem_rdata;
          if (slot_q == SW'(1))    status_d   = mem_rdata;
          if (slot_q == LAST) begin
            state_d = ST_WRITE;
            slot_d  = '0;
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end
      end
      ST_WRITE: begin
        if (accept) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          fcx_o_d  = {fcx_q[W-1:LNK_PTR_W], link_q[LNK_PTR_W-1:0]};
          link_o_d = new_link_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      link_q     <= '0;
      fcx_q      <= '0;
      new_link_q <= '0;
      status_q   <= '0;
      icr_q      <= '0;
      fcx_o_q    <= '0;
      link_o_q   <= '0;
      done_q     <= 1'b0;
      tv_q       <= 1'b0;
      tc_q       <= 2'd0;
    end else begin
      state_q    <= state_d;
      slot_q     <= slot_d;
      link_q     <= link_d;
      fcx_q      <= fcx_d;
      new_link_q <= new_link_d;
      status_q   <= status_d;
      icr_q      <= icr_d;
      fcx_o_q    <= fcx_o_d;
      link_o_q   <= link_o_d;
      done_q     <= done_d;
      tv_q       <= tv_d;
      tc_q       <= tc_d;
    end
  end

  assign slot        = slot_q;
  assign link_q_o    = link_q;
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign trap_valid  = tv_q;
  assign trap_code   = tc_q;
  assign mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we      = (state_q == ST_WRITE);
  assign mem_addr    = (state_q == ST_WRITE) ? base : slot_addr;
  assign mem_wdata   = (state_q == ST_WRITE) ? fcx_q : '0;
  assign link_out    = link_o_q;
  assign status_out  = status_q;
  assign icr_out     = icr_q;
  assign fcx_out     = fcx_o_q;
  assign ctx_wr_en   = (state_q == ST_READ) && mem_ready;
  assign ctx_wr_idx  = slot_q;
  assign ctx_wr_data = (state_q == ST_READ) ? mem_rdata : '0;

  assert_trap_no_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!mem_req && !done));

  assert_trap_code_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_code != 2'd0));

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_addr_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[27:22] == 6'd0 && mem_addr[1:0] == 2'd0));

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_we && mem_ready));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rfe_restore_seq.sv
module rfe_restore_seq
  import rfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] link_in,
  input  logic [31:0] status_in,
  input  logic [31:0] icr_in,
  input  logic [31:0] fcx_in,
  output logic        busy,
  output logic        done,
  output logic        trap_valid,
  output logic [1:0]  trap_code,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic [31:0] link_out,
  output logic [31:0] status_out,
  output logic [31:0] icr_out,
  output logic [31:0] fcx_out,
  output logic        ctx_wr_en,
  output logic [3:0]  ctx_wr_idx,
  output logic [31:0] ctx_wr_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  trap_e             trap;
  logic [SLOT_W-1:0] slot;
  logic [WORD_W-1:0] link_q, base, slot_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  rfe_trap_check #(.W(WORD_W)) u_check (
    .link   (link_in),
    .status (status_in),
    .trap   (trap)
  );

  rfe_addr_gen #(.W(WORD_W), .SLOTS(CTX_WORDS)) u_addr (
    .link      (link_q),
    .slot      (slot),
    .base      (base),
    .slot_addr (slot_addr)
  );

  rfe_seq_ctrl #(.W(WORD_W), .SLOTS(CTX_WORDS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .trap_in     (trap),
    .link_in     (link_in),
    .icr_in      (icr_in),
    .fcx_in      (fcx_in),
    .base        (base),
    .slot_addr   (slot_addr),
    .slot        (slot),
    .link_q_o    (link_q),
    .busy        (busy),
    .done        (done),
    .trap_valid  (trap_valid),
    .trap_code   (trap_code),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ready   (mem_ready),
    .link_out    (link_out),
    .status_out  (status_out),
    .icr_out     (icr_out),
    .fcx_out     (fcx_out),
    .ctx_wr_en   (ctx_wr_en),
    .ctx_wr_idx  (ctx_wr_idx),
    .ctx_wr_data (ctx_wr_data)
  );
endmodule

// File: tb/test_rfe_restore_seq.sv
module test_rfe_restore_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] link_in, status_in, icr_in, fcx_in;
  logic        busy, done, trap_valid;
  logic [1:0]  trap_code;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ready;
  logic [31:0] link_out, status_out, icr_out, fcx_out;
  logic        ctx_wr_en;
  logic [3:0]  ctx_wr_idx;
  logic [31:0] ctx_wr_data;

  int tests = 0;
  int fails = 0;
  int stall_cnt = 0;

  always #5 clk = ~clk;

  rfe_restore_seq i_rfe_restore_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .link_in(link_in), .status_in(status_in), .icr_in(icr_in), .fcx_in(fcx_in),
    .busy(busy), .done(done), .trap_valid(trap_valid), .trap_code(trap_code),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .link_out(link_out), .status_out(status_out), .icr_out(icr_out), .fcx_out(fcx_out),
    .ctx_wr_en(ctx_wr_en), .ctx_wr_idx(ctx_wr_idx), .ctx_wr_data(ctx_wr_data)
  );

  // {link, status, expected trap code}
  localparam int NV = 13;
  localparam logic [65:0] VEC [NV] = '{
    {32'h5B37_1234, 32'h0000_0080, 2'd0},  // R3 depth 0 enabled
    {32'h5B37_1234, 32'h0000_0081, 2'd3},  // R3 6-bit counter = 1
    {32'h1210_0001, 32'h0000_00C0, 2'd0},  // R4 5-bit counter = 0
    {32'h1210_0001, 32'h0000_00DF, 2'd3},  // R4 5-bit counter = 31
    {32'hFF1F_FFFF, 32'h0000_00FE, 2'd0},  // R4 width zero
    {32'hFF1F_FFFF, 32'h0000_00FF, 2'd0},  // R4 all ones
    {32'h0034_8000, 32'h0000_00FD, 2'd3},  // R4 1-bit counter = 1
    {32'h0034_8000, 32'h0000_00FC, 2'd0},  // R4 1-bit counter = 0
    {32'h5B37_1234, 32'h0000_0001, 2'd0},  // R3 check disabled
    {32'h0000_0000, 32'h0000_0081, 2'd1},  // R5 underflow beats type and nesting
    {32'h0010_0000, 32'h0000_0080, 2'd1},  // R1 zero pointer with flag set
    {32'h0001_0000, 32'h0000_0081, 2'd2},  // R5 type beats nesting
    {32'h0020_0005, 32'h0000_0000, 2'd2}   // R2 flag clear
  };

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h0F0F_1234;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_restore(input logic [31:0] lk, input logic [31:0] fx, input logic [31:0] ic);
    logic [31:0] ea;
    logic [31:0] exp_icr;
    int k;
    bit fin;
    bit rd;
    ea = {lk[19:16], 6'b0, lk[15:0], 6'b0};
    exp_icr = {ic[31:9], lk[21], lk[31:24]};
    k = 0;
    fin = 0;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      @(negedge clk);
      stall_cnt++;
      rd = mem_req && !mem_we;
      mem_ready = mem_req && ((stall_cnt % 3) != 2);
      mem_rdata = mem_ready && rd ? mem_val(mem_addr) : 32'h0;
      #1;
      if (mem_ready && rd) begin
        chk(mem_addr == ea + 32'(4*k), "R7", mem_addr, ea + 32'(4*k));
        chk(ctx_wr_en && ctx_wr_idx == 4'(k) && ctx_wr_data == mem_val(ea + 32'(4*k)),
            "R8", {28'h0, ctx_wr_idx}, 32'(k));
        k++;
      end else if (mem_ready && mem_we) begin
        chk(k == 16, "R9 read count", 32'(k), 32'd16);
        chk(mem_addr == ea && mem_wdata == fx, "R9", mem_wdata, fx);
        @(negedge clk);
        mem_ready = 1'b0;
        #1;
        chk(done && !busy, "R12", {30'h0, done, busy}, 32'h2);
        chk(fcx_out == {fx[31:20], lk[19:0]}, "R10 fcx", fcx_out, {fx[31:20], lk[19:0]});
        chk(link_out == mem_val(ea), "R10 link", link_out, mem_val(ea));
        chk(status_out == mem_val(ea + 32'd4), "R8 status", status_out, mem_val(ea + 32'd4));
        chk(icr_out == exp_icr, "R6", icr_out, exp_icr);
        @(negedge clk);
        chk(!done, "R12 pulse", {31'h0, done}, 32'h0);
        fin = 1;
      end else if (mem_req) begin
        chk(!ctx_wr_en, "R11 no strobe in stall", {31'h0, ctx_wr_en}, 32'h0);
      end
    end
    chk(fin, "R12 completion", {31'h0, fin}, 32'h1);
    mem_ready = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog R12 actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    link_in = '0; status_in = '0; icr_in = '0; fcx_in = '0;
    mem_ready = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !trap_valid && !mem_req && link_out == 0 && fcx_out == 0 &&
        icr_out == 0 && status_out == 0 && !ctx_wr_en, "R13", {28'h0, busy, done, trap_valid, mem_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] lk, st, fx, ic;
      logic [1:0]  ec;
      {lk, st, ec} = VEC[i];
      fx = 32'hFED0_0000 | 32'(i * 32'h1111);
      ic = 32'h1234_5600 ^ 32'(i);
      @(negedge clk);
      link_in = lk; status_in = st; fcx_in = fx; icr_in = ic;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (ec != 2'd0) begin
        chk(trap_valid && trap_code == ec, (ec == 2'd1) ? "R1" : (ec == 2'd2) ? "R2" : "R3",
            {30'h0, trap_code}, {30'h0, ec});
        chk(!mem_req && !busy, "R1 no access after trap", {30'h0, mem_req, busy}, 32'h0);
        @(negedge clk);
        chk(!trap_valid && !done && !mem_req, "R5 single report", {29'h0, trap_valid, done, mem_req}, 32'h0);
      end else begin
        chk(!trap_valid && busy, "R4 no trap", {30'h0, trap_valid, busy}, 32'h1);
        run_restore(lk, fx, ic);
      end
    end

    // R11: start while busy is ignored; sequence finishes with first operands
    @(negedge clk);
    link_in = 32'h5B37_1234; status_in = 32'h0; fcx_in = 32'hAAA0_0000; icr_in = 32'h0;
    start = 1'b1;
    @(negedge clk);
    link_in = 32'h0000_0000; fcx_in = 32'h5550_0000;
    @(negedge clk);
    start = 1'b0;
    chk(!trap_valid && busy, "R11 start ignored while busy", {30'h0, trap_valid, busy}, 32'h1);
    run_restore(32'h5B37_1234, 32'hAAA0_0000, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule